// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block is the address stage at the front of an I2C target. It synchronizes the bus lines into the system clock and detects START, repeated START and STOP. After each START it collects the first byte. Bits [7:1] of that byte form the 7-bit address, and the block compares them with the programmed `dev_addr_i`. During the ninth SCL period it either pulls SDA low (ACK) or leaves SDA released (NACK).

When the address matches, the block raises a one-cycle `match_o` strobe and presents the direction bit on `rw_o`. It then holds `selected_o` high so a downstream byte engine can take the transfer. When the address does not match, the block stays silent on the bus until the next START or STOP.

The compare is purely numeric. Reserved addresses and the 10-bit prefix pattern get no special treatment, and no second address byte is ever expected. The one exception is the all-zero general call, which is always refused.

Top module: `i2c_addr_filter`

## Requirements
- R1: After reset `sda_oe_o`, `match_o` and `selected_o` are 0.
- R2: A START (SDA falling while SCL is high) in any state discards any partly received byte and restarts address reception. This also applies to a repeated START in the middle of a byte or a transfer.
- R3: Address bits are sampled MSB first on SCL rising edges. Received bits [7:1] are compared with `dev_addr_i`, and bit 0 is the direction (1 = read).
- R4: On a match, `sda_oe_o` (1 = pull SDA low) goes high at the SCL fall that ends the eighth bit and drops at the next SCL fall. At the start of that ACK, `match_o` pulses for one cycle and `rw_o` carries the received direction bit.
- R5: On a mismatch, SDA stays released for the ninth bit and `match_o` does not pulse. Later bytes are not acknowledged, even if they carry the device address, until a START or STOP.
- R6: The general call address 0000000 is always NACKed, even when `dev_addr_i` is 0. The rest of that transfer is ignored.
- R7: Reserved addresses, including 0000001, 11110xx and 11111xx, are compared as ordinary 7-bit values. They are ACKed exactly when they equal `dev_addr_i`.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle: `selected_o` and `sda_oe_o` go to 0.
- R9: `selected_o` is high from the ACK until the next START or STOP. Data bytes after a matched address are not acknowledged by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| dev_addr_i | input | ADDR_W | Programmed 7-bit device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| match_o | output | 1 | One-cycle strobe when the address is accepted |
| rw_o | output | 1 | Direction bit of the accepted address (1 = read) |
| selected_o | output | 1 | Transfer owned by the downstream engine |

## Verification
The embedded properties check, on every cycle, four things:
- the SDA driver only changes while the synchronized SCL is low, or right after a bus condition;
- the match strobe lasts one cycle and never accompanies an all-zero address;
- a STOP always leaves the block idle and released;
- a START always clears the bit counter.

Only the bench's bus scenarios can show which addresses are actually ACKed against each programmed value, which direction bit reaches `rw_o`, and what happens on the bus after a NACK, an aborted byte or a data byte that follows a match.

// File: rtl/i2c_af_pkg.sv
package i2c_af_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEL,
    ST_IGN
  } af_state_e;
endpackage

// File: rtl/i2c_af_sync.sv
module i2c_af_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] ff_q;
  logic              last_q;

  // Idle bus is high: reset to 1 so no false edge appears after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q   <= '1;
      last_q <= 1'b1;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
      last_q <= ff_q[STAGES-1];
    end
  end

  assign q_o    = ff_q[STAGES-1];
  assign rise_o = ff_q[STAGES-1] & ~last_q;
  assign fall_o = ~ff_q[STAGES-1] & last_q;
endmodule

// File: rtl/i2c_af_cond.sv
module i2c_af_cond (
  input  logic scl_hi_i,
  input  logic scl_edge_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // SCL must be steadily high, not just rising in the same cycle
  logic scl_steady;
  assign scl_steady = scl_hi_i & ~scl_edge_i;
  assign start_o    = sda_fall_i & scl_steady;
  assign stop_o     = sda_rise_i & scl_steady;
endmodule

// File: rtl/i2c_af_shreg.sv
module i2c_af_shreg #(
  parameter int W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     shift_i,
  input  logic                     bit_i,
  output logic [W-1:0]             data_o,
  output logic [$clog2(W+1)-1:0]   cnt_o
);
  localparam int CW = $clog2(W+1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  data_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i && cnt_q < FULL) begin
      data_q <= {data_q[W-2:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign data_o = data_q;
  assign cnt_o  = cnt_q;

  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL && !clr_i) |=> $stable(data_q));
endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter
  import i2c_af_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_oe_o,
  output logic              match_o,
  output logic              rw_o,
  output logic              selected_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CW     = $clog2(BYTE_W + 1);
  localparam int LINES  = 2;
  localparam logic [CW-1:0] BYTE_DONE = CW'(BYTE_W);

  logic [LINES-1:0] line_raw, line_s, line_rise, line_fall;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_af_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw[g]),
      .q_o    (line_s[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  logic scl_s, scl_rise, scl_fall, sda_s;
  assign scl_s    = line_s[0];
  assign scl_rise = line_rise[0];
  assign scl_fall = line_fall[0];
  assign sda_s    = line_s[1];

  logic start_det, stop_det;
  i2c_af_cond u_cond (
    .scl_hi_i   (scl_s),
    .scl_edge_i (scl_rise | scl_fall),
    .sda_rise_i (line_rise[1]),
    .sda_fall_i (line_fall[1]),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  af_state_e         state_q;
  logic [BYTE_W-1:0] sh_data;
  logic [CW-1:0]     sh_cnt;
  logic              shift_en;

  assign shift_en = (state_q == ST_ADDR) & scl_rise;

  i2c_af_shreg #(.W(BYTE_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_det),
    .shift_i (shift_en),
    .bit_i   (sda_s),
    .data_o  (sh_data),
    .cnt_o   (sh_cnt)
  );

  logic [ADDR_W-1:0] rx_addr;
  logic              addr_hit;
  assign rx_addr  = sh_data[BYTE_W-1:1];
  // all-zero (general call) is never accepted
  assign addr_hit = (rx_addr == dev_addr_i) && (|rx_addr);

  logic oe_q, match_q, rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      match_q <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        rw_q    <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        oe_q    <= 1'b0;
        rw_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_fall && sh_cnt == BYTE_DONE) begin
              if (addr_hit) begin
                state_q <= ST_ACK;
                oe_q    <= 1'b1;
                match_q <= 1'b1;
                rw_q    <= sh_data[0];
              end else begin
                state_q <= ST_IGN;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state_q <= ST_SEL;
              oe_q    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign match_o    = match_q;
  assign rw_o       = rw_q;
  assign selected_o = (state_q == ST_ACK) || (state_q == ST_SEL);

  // R4
  match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
  // R4
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (!scl_s && match_o));
  // R4
  oe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> (!scl_s || $past(start_det || stop_det)));
  // R6
  gc_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (|rx_addr));
  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!selected_o && !sda_oe_o));
  // R2
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !stop_det) |=> (sh_cnt == '0 && state_q == ST_ADDR));
endmodule

// File: tb/tb_i2c_addr_filter.sv
module tb_i2c_addr_filter;
  localparam int Q = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] dev_addr = 7'h00;
  logic       sda_oe, match, rw, selected;
  logic       sda_bus;

  int errors = 0;
  int checks = 0;
  int match_cnt = 0;
  logic last_rw = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_addr_filter dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .dev_addr_i (dev_addr),
    .sda_oe_o   (sda_oe),
    .match_o    (match),
    .rw_o       (rw),
    .selected_o (selected)
  );

  always @(negedge clk) if (match) begin
    match_cnt++;
    last_rw = rw;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b0; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b1; qw();
    qw();
  endtask

  task automatic do_bit(input logic b, output logic low_seen);
    m_sda = b; qw();
    m_scl = 1'b1; qw();
    low_seen = ~sda_bus; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic do_bits(input logic [7:0] v, input int n);
    logic dummy;
    for (int i = 7; i > 7 - n; i--) do_bit(v[i], dummy);
  endtask

  task automatic do_byte(input logic [7:0] v, output logic ack);
    do_bits(v, 8);
    do_bit(1'b1, ack);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    int m0;
    logic [6:0] devs [4];
    devs[0] = 7'h00; devs[1] = 7'h55; devs[2] = 7'h78; devs[3] = 7'h7F;

    repeat (4) @(negedge clk);
    // R1
    chk("R1 oe", sda_oe, 0);
    chk("R1 match", match, 0);
    chk("R1 selected", selected, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep: every address against each programmed value (R3, R6, R7, R4, R8)
    for (int d = 0; d < 4; d++) begin
      dev_addr = devs[d];
      for (int a = 0; a < 128; a++) begin
        logic [6:0] av;
        logic rwb;
        int exp;
        string tag;
        av  = 7'(a);
        rwb = av[0] ^ devs[d][0];
        exp = (av == devs[d] && av != 0) ? 1 : 0;
        if (av == 0) tag = "R6";
        else if (av < 8 || av[6:3] == 4'b1111) tag = "R7";
        else tag = "R3";
        m0 = match_cnt;
        do_start();
        do_byte({av, rwb}, ack);
        chk(tag, int'(ack), exp);
        chk("R4 strobe", match_cnt - m0, exp);
        if (exp == 1) chk("R4 rw", int'(last_rw), int'(rwb));
        chk("R9 selected", int'(selected), exp);
        do_stop();
        chk("R8 idle", int'(selected | sda_oe), 0);
      end
    end

    dev_addr = 7'h2A;
    // R2: repeated START aborts a half byte, then matching read address
    do_start();
    do_bits({7'h2A, 1'b0}, 4);
    m0 = match_cnt;
    do_start();
    do_byte({7'h2A, 1'b1}, ack);
    chk("R2 ack after restart", int'(ack), 1);
    chk("R2 rw", int'(last_rw), 1);
    chk("R2 strobe", match_cnt - m0, 1);
    do_stop();

    // R2: partial matching bits then restart with a different address
    do_start();
    do_bits({7'h2A, 1'b0}, 5);
    do_start();
    do_byte({7'h2B, 1'b0}, ack);
    chk("R2 nack other", int'(ack), 0);
    do_stop();

    // R5: after NACK a byte carrying the device address is ignored
    do_start();
    m0 = match_cnt;
    do_byte({7'h11, 1'b0}, ack);
    chk("R5 nack", int'(ack), 0);
    do_byte({7'h2A, 1'b0}, ack);
    chk("R5 ignored byte", int'(ack), 0);
    chk("R5 no strobe", match_cnt - m0, 0);
    chk("R5 not selected", int'(selected), 0);
    do_stop();

    // R9: data byte after match is not acknowledged by this block
    do_start();
    do_byte({7'h2A, 1'b0}, ack);
    chk("R9 addr ack", int'(ack), 1);
    do_byte(8'h00, ack);
    chk("R9 data not acked", int'(ack), 0);
    chk("R9 still selected", int'(selected), 1);
    // R6: repeated START with general call while selected
    m0 = match_cnt;
    do_start();
    do_byte(8'h00, ack);
    chk("R6 gc nack", int'(ack), 0);
    chk("R6 deselected", int'(selected), 0);
    do_byte({7'h2A, 1'b0}, ack);
    chk("R6 rest ignored", int'(ack), 0);
    chk("R6 no strobe", match_cnt - m0, 0);
    do_stop();

    // R8: STOP mid-byte, then normal recovery
    do_start();
    do_bits({7'h2A, 1'b0}, 3);
    do_stop();
    chk("R8 mid stop idle", int'(selected | sda_oe), 0);
    do_start();
    do_byte({7'h2A, 1'b0}, ack);
    chk("R8 recover ack", int'(ack), 1);
    do_stop();
    chk("R8 final idle", int'(selected | sda_oe), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule